// File: doc/BRIEF.md
# Buck PWM Gate Sequencer

This block sequences the two power switches of a synchronous step-down stage under fixed-frequency peak-current-mode control. A free-running period counter marks each switching cycle. At the start of every cycle the high-side switch is requested on. The request ends at the first of three events: the PWM comparator trips (the error voltage has met the ramp), the high-side current limit fires, or the on-time reaches the maximum duty. For the rest of the cycle the low-side switch is requested on. A low-side sink-limit flag ends that low-side request early for the remaining part of the cycle.

The comparator outputs come in as synchronous digital flags. During a leading-edge blanking window at the start of the cycle they are ignored, so switching noise cannot end a pulse shorter than the minimum on-time. A break-before-make stage converts each request into a gate enable only after the request has been steady for a programmable dead time. Because one request always falls on the same clock edge that the other rises, there is a gap of exactly that dead time between the two gates. A per-cycle flag tells the fault logic whether the current limit, and not the loop, ended the on-time.

With a 100 MHz system clock the defaults give a 1 MHz cycle, a 95 % duty ceiling, 100 ns of blanking and 20 ns of dead time.

Top module: `buck_gate_seq`

## Requirements
- R1: The cycle position counts 0 to PERIOD_CLKS-1 and wraps. The first clock after reset release is position 0. The high-side request rises at position 0 of every cycle, and the high-side gate turns on at position DEAD_CLKS.
- R2: When pwm_trip is sampled high at a position X (X ≥ BLANK_CLKS) while the high side is requested, X is the last position at which the high-side gate is on.
- R3: When hs_ilim is sampled high at such a position X, the on-time ends in the same way, and ilim_end is high from position X+1 to the end of the cycle.
- R4: With MAXON = PERIOD_CLKS*MAX_DUTY_PCT/100 (integer division), the high-side gate is never on at a position of MAXON or above. If nothing else ends the on-time, it ends after position MAXON-1.
- R5: pwm_trip and hs_ilim have no effect at positions below BLANK_CLKS, and they have no effect once the on-time has ended.
- R6: The low-side request is high from the position after the on-time ends (X+1) through position PERIOD_CLKS-1. The low-side gate is on from position X+1+DEAD_CLKS until its request ends.
- R7: When ls_sink_lim is sampled high at a position S while the low side is requested, S is the last position of that low-side request for the cycle. The flag has no effect while the high side is requested.
- R8: hs_gate and ls_gate are never high together. Each gate turns on only after the other gate has been off for at least DEAD_CLKS clocks.
- R9: ilim_end is low from position 0 through the end of the on-time. It stays low for the cycle when the on-time was ended by pwm_trip or by the maximum duty. When pwm_trip and hs_ilim end the on-time together, ilim_end is set.
- R10: While rst_n is low, hs_gate, ls_gate and ilim_end are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_trip | input | 1 | PWM comparator flag: the error voltage has crossed the ramp |
| hs_ilim | input | 1 | High-side peak current limit flag |
| ls_sink_lim | input | 1 | Low-side reverse (sink) current limit flag |
| hs_gate | output | 1 | High-side gate-drive enable |
| ls_gate | output | 1 | Low-side gate-drive enable |
| ilim_end | output | 1 | The current limit ended this cycle's on-time |

## Verification
The gate outputs show the cycle position directly. A counter that is off by one, or that does not wrap, moves the rising edge of hs_gate away from position DEAD_CLKS within the cycle in which the error occurs. A wrong termination decision shows as a high-side pulse whose last position differs from the first eligible flag position, or from MAXON-1. A wrong cause bit shows on ilim_end one clock after the pulse ends. A dead-time counter that does not clear produces a gap that is too short, or an overlap, at the very next transition between the gates.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

  // Number of cycle positions during which the high side may be requested.
  function automatic int unsigned max_on_clks(input int unsigned period,
                                              input int unsigned pct);
    int unsigned r;
    r = (period * pct) / 100;
    if (r < 1) r = 1;
    return r;
  endfunction

  // Width of a counter that must hold the values 0..n.
  function automatic int unsigned hold_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int unsigned PERIOD_CLKS = 100,
  localparam int unsigned CW = buck_gate_pkg::hold_width(PERIOD_CLKS - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          cyc_last
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CLKS - 1);

  logic [CW-1:0] cnt_q;

  // Reset parks the counter on the last position, so the first edge opens a cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= LAST;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt      = cnt_q;
  assign cyc_last = (cnt_q == LAST);
endmodule

// File: rtl/on_time_ctrl.sv
module on_time_ctrl #(
  parameter int unsigned PERIOD_CLKS  = 100,
  parameter int unsigned MAX_DUTY_PCT = 95,
  parameter int unsigned BLANK_CLKS   = 10,
  localparam int unsigned CW    = buck_gate_pkg::hold_width(PERIOD_CLKS - 1),
  localparam int unsigned MAXON = buck_gate_pkg::max_on_clks(PERIOD_CLKS, MAX_DUTY_PCT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          cyc_last,
  input  logic          pwm_trip,
  input  logic          hs_ilim,
  input  logic          ls_sink_lim,
  output logic          hs_req,
  output logic          ls_req,
  output logic          ilim_end,
  output logic          on_end,
  output logic          ilim_cause
);
  localparam logic [CW-1:0] BLANK_C  = CW'(BLANK_CLKS);
  localparam logic [CW-1:0] LASTON_C = CW'(MAXON - 1);

  logic hs_q, ls_q, flag_q;
  logic past_blank, hit_trip, hit_ilim, hit_max;

  always_comb begin
    past_blank = (cnt >= BLANK_C);
    hit_trip   = hs_q && past_blank && pwm_trip;
    hit_ilim   = hs_q && past_blank && hs_ilim;
    hit_max    = hs_q && (cnt == LASTON_C);
    on_end     = hit_trip || hit_ilim || hit_max;
    ilim_cause = hit_ilim;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      flag_q <= 1'b0;
    end else if (cyc_last) begin
      hs_q   <= 1'b1;
      ls_q   <= 1'b0;
      flag_q <= 1'b0;
    end else if (on_end) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b1;
      flag_q <= ilim_cause;
    end else if (ls_q && ls_sink_lim) begin
      ls_q   <= 1'b0;
    end
  end

  assign hs_req   = hs_q;
  assign ls_req   = ls_q;
  assign ilim_end = flag_q;
endmodule

// File: rtl/dead_time_gate.sv
module dead_time_gate #(
  parameter int unsigned DEAD_CLKS = 2,
  localparam int unsigned AW = buck_gate_pkg::hold_width(DEAD_CLKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic gate
);
  localparam logic [AW-1:0] FULL = AW'(DEAD_CLKS);

  logic [AW-1:0] age_q;

  // Counts how long the request has been held steady; saturates at the dead time.
  always_ff @(posedge clk) begin
    if (!rst_n || !req)   age_q <= '0;
    else if (age_q != FULL) age_q <= age_q + 1'b1;
  end

  assign gate = req && (age_q == FULL);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int unsigned PERIOD_CLKS  = 100,
  parameter int unsigned MAX_DUTY_PCT = 95,
  parameter int unsigned BLANK_CLKS   = 10,
  parameter int unsigned DEAD_CLKS    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_trip,
  input  logic hs_ilim,
  input  logic ls_sink_lim,
  output logic hs_gate,
  output logic ls_gate,
  output logic ilim_end
);
  localparam int unsigned CW = buck_gate_pkg::hold_width(PERIOD_CLKS - 1);

  logic [CW-1:0] cnt;
  logic          cyc_last;
  logic          on_end, ilim_cause;
  logic          hs_req, ls_req;
  logic [1:0]    req_vec, gate_vec;

  cycle_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cyc_last(cyc_last)
  );

  on_time_ctrl #(
    .PERIOD_CLKS(PERIOD_CLKS), .MAX_DUTY_PCT(MAX_DUTY_PCT), .BLANK_CLKS(BLANK_CLKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cyc_last(cyc_last),
    .pwm_trip(pwm_trip), .hs_ilim(hs_ilim), .ls_sink_lim(ls_sink_lim),
    .hs_req(hs_req), .ls_req(ls_req), .ilim_end(ilim_end),
    .on_end(on_end), .ilim_cause(ilim_cause)
  );

  assign req_vec = {ls_req, hs_req};

  for (genvar g = 0; g < 2; g++) begin : g_dead
    dead_time_gate #(.DEAD_CLKS(DEAD_CLKS)) u_dt (
      .clk(clk), .rst_n(rst_n), .req(req_vec[g]), .gate(gate_vec[g])
    );
  end

  assign hs_gate = gate_vec[0];
  assign ls_gate = gate_vec[1];
endmodule

// File: rtl/buck_gate_seq_chk.sv
module buck_gate_seq_chk #(
  parameter int unsigned PERIOD_CLKS  = 100,
  parameter int unsigned MAX_DUTY_PCT = 95,
  parameter int unsigned BLANK_CLKS   = 10,
  parameter int unsigned DEAD_CLKS    = 2,
  localparam int unsigned CW    = buck_gate_pkg::hold_width(PERIOD_CLKS - 1),
  localparam int unsigned MAXON = buck_gate_pkg::max_on_clks(PERIOD_CLKS, MAX_DUTY_PCT),
  localparam int unsigned OW    = buck_gate_pkg::hold_width(DEAD_CLKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          cyc_last,
  input logic          on_end,
  input logic          hs_ilim,
  input logic          hs_gate,
  input logic          ls_gate,
  input logic          ilim_end
);
  localparam logic [OW-1:0] FULL = OW'(DEAD_CLKS);

  logic [OW-1:0] hs_off_n, ls_off_n;

  // Number of clocks for which each gate has been off, saturating at the dead time.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_off_n <= FULL;
      ls_off_n <= FULL;
    end else begin
      hs_off_n <= hs_gate ? '0 : ((hs_off_n == FULL) ? FULL : hs_off_n + 1'b1);
      ls_off_n <= ls_gate ? '0 : ((ls_off_n == FULL) ? FULL : ls_off_n + 1'b1);
    end
  end

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  // R8
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> (ls_off_n == FULL));

  // R8
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> (hs_off_n == FULL));

  // R4
  max_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> (cnt < CW'(MAXON)));

  // R5
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_end |-> (cnt >= CW'(BLANK_CLKS)));

  // R3
  ilim_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_end && hs_ilim && !cyc_last) |=> ilim_end);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last |=> !ilim_end);

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last |=> (!ls_gate && !hs_gate));
endmodule

bind buck_gate_seq buck_gate_seq_chk #(
  .PERIOD_CLKS(PERIOD_CLKS), .MAX_DUTY_PCT(MAX_DUTY_PCT),
  .BLANK_CLKS(BLANK_CLKS), .DEAD_CLKS(DEAD_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cyc_last(cyc_last), .on_end(on_end),
  .hs_ilim(hs_ilim), .hs_gate(hs_gate), .ls_gate(ls_gate), .ilim_end(ilim_end)
);

// File: tb/test_buck_gate_seq.sv
module test_buck_gate_seq;
  localparam int P     = 20;
  localparam int PCT   = 95;
  localparam int BL    = 4;
  localparam int DT    = 2;
  localparam int MAXON = (P * PCT) / 100;
  localparam int NEVER = 1000;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_trip = 1'b0, hs_ilim = 1'b0, ls_sink_lim = 1'b0;
  logic hs_gate, ls_gate, ilim_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  buck_gate_seq #(
    .PERIOD_CLKS(P), .MAX_DUTY_PCT(PCT), .BLANK_CLKS(BL), .DEAD_CLKS(DT)
  ) i_buck_gate_seq (
    .clk(clk), .rst_n(rst_n), .pwm_trip(pwm_trip), .hs_ilim(hs_ilim),
    .ls_sink_lim(ls_sink_lim), .hs_gate(hs_gate), .ls_gate(ls_gate),
    .ilim_end(ilim_end)
  );

  task automatic check(input logic act, input logic exp, input string tag,
                       input string what, input int pos);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at position %0d: actual=%0b expected=%0b",
               tag, what, pos, act, exp);
    end
  endtask

  // One whole switching cycle. Each flag is high for positions in [a, b).
  task automatic run_cycle(input string tag, input int ta, input int tb,
                           input int ia, input int ib, input int sa, input int sb);
    int x, s;
    bit cause;
    x = MAXON - 1;
    for (int c = MAXON - 2; c >= BL; c--)
      if ((c >= ta && c < tb) || (c >= ia && c < ib)) x = c;
    cause = (x >= BL) && (x >= ia && x < ib);
    s = P - 1;
    for (int c = P - 1; c >= x + 1; c--)
      if (c >= sa && c < sb) s = c;
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      check(hs_gate, (c >= DT && c <= x), tag, "hs_gate", c);
      check(ls_gate, (c >= x + 1 + DT && c <= s),
            (s < P - 1) ? "R7" : "R6", "ls_gate", c);
      check(ilim_end, cause && (c > x), cause ? "R3" : "R9", "ilim_end", c);
      check(hs_gate && ls_gate, 1'b0, "R8", "overlap", c);
      pwm_trip    = (c >= ta && c < tb);
      hs_ilim     = (c >= ia && c < ib);
      ls_sink_lim = (c >= sa && c < sb);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(hs_gate, 1'b0, "R10", "hs_gate in reset", 0);
    check(ls_gate, 1'b0, "R10", "ls_gate in reset", 0);
    check(ilim_end, 1'b0, "R10", "ilim_end in reset", 0);
    rst_n = 1'b1;

    // R1 / R4: no flags, the on-time ends at maximum duty
    run_cycle("R4", NEVER, NEVER, NEVER, NEVER, NEVER, NEVER);
    run_cycle("R1", NEVER, NEVER, NEVER, NEVER, NEVER, NEVER);
    // R2: trip held from every position (positions after the on-time are ignored, R5)
    for (int t = 0; t < P; t++) run_cycle("R2", t, P, NEVER, NEVER, NEVER, NEVER);
    // R3: current limit held from every position
    for (int t = 0; t < P; t++) run_cycle("R3", NEVER, NEVER, t, P, NEVER, NEVER);
    // R9: both flags together set the cause bit
    for (int t = BL; t < MAXON; t++) run_cycle("R9", t, P, t, P, NEVER, NEVER);
    // R9: trip first, current limit one position later
    for (int t = BL; t < MAXON - 1; t++) run_cycle("R9", t, P, t + 1, P, NEVER, NEVER);
    // R5: pulses confined to the blanking window are ignored
    for (int t = 0; t < BL; t++) run_cycle("R5", t, BL, NEVER, NEVER, NEVER, NEVER);
    for (int t = 0; t < BL; t++) run_cycle("R5", NEVER, NEVER, t, BL, NEVER, NEVER);
    // R7: single-position sink pulse at every position, trip at position 8
    for (int s = 0; s < P; s++) run_cycle("R7", 8, P, NEVER, NEVER, s, s + 1);
    // R7: sink held from every position, with a late current limit
    for (int s = 0; s < P; s++) run_cycle("R7", NEVER, NEVER, 12, P, s, P);
    // R1: plain cycle after the sweeps
    run_cycle("R1", 6, P, NEVER, NEVER, NEVER, NEVER);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule